// File: doc/BRIEF.md
# Programmable Skew-Tap Clock Phase Shifter

This block is a digital model of one output bank of a skew-programmable clock driver. A fast tick clock runs at N times the bank's nominal output frequency. A reference phase marker pulses for one tick at each reference edge. The bank produces two matched clocks of period N ticks, and these clocks lead or lag the reference by a whole number of ticks. One tick is one skew time unit. A three-level range select sets N to 44, 26 or 16.

Each bank is set by a two-digit three-level code, which gives nine settings. A bank-type input selects the divider bank. On that bank every skew is doubled, and the two extreme codes replace skew with a divide-by-2 or a divide-by-4 output. The range, code and bank type are captured only when a reference cycle starts. The analog loop and the sensing of three-level pads are outside the block, so each three-level value arrives already decoded.

Top module: `skew_tap_shifter`

## Requirements
- R1: The three-level encoding is 2'b00 = L, 2'b01 = M and 2'b10 = H. Range L, M and H give a cycle of 44, 26 and 16 ticks respectively, and the outputs repeat with that period.
- R2: A three-level input at 2'b11 (undriven) behaves exactly as M. This applies to both range and code digits.
- R3: On a normal bank, let the code index be 3*hi + lo (code_i[3:2] = hi, code_i[1:0] = lo, with L=0, M=1, H=2). The skew s is index − 4 ticks, so LL = −4 and HH = +4. When the marker is sampled at edge 0 and recurs every N ticks, the output after edge t+1 is 1 exactly when (((t mod N) − s) mod N) < N/2. A negative s therefore leads the reference edge and a positive s lags it.
- R4: Code MM gives zero skew, and the output rises one tick after the marker edge. MM is also the setting held from reset.
- R5: In skew mode each output is high for N/2 ticks and low for N/2 ticks of every cycle.
- R6: On the divider bank (div_bank_i = 1), codes LM through HM give a skew of 2*(index − 4) ticks, which spans −6 to +6.
- R7: On the divider bank, LL gives divide-by-2 (high in even reference cycles) and HH gives divide-by-4 (high in cycles 0 and 1 of every 4). Cycles are counted from the first marker after reset, both outputs have a 50% duty cycle, and they change only at a cycle start.
- R8: Both bank outputs are identical at every tick.
- R9: A change to the range, code or bank type takes effect only at the next cycle start (marker or wrap). Until then the outputs follow the old setting.
- R10: During reset both outputs are 0. A marker restarts the tick-phase count at 0 on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast tick clock (one skew unit per tick) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_mark_i | input | 1 | One-tick pulse at each reference edge |
| range_i | input | 2 | Three-level range select |
| code_i | input | 4 | Two-digit three-level skew code, hi digit in [3:2] |
| div_bank_i | input | 1 | 1 selects the divider bank |
| q_o | output | NUM_OUT | Bank clock outputs |

## Verification
Each output is registered once after the phase counter. The value seen after edge t+1 therefore reflects the phase set at edge t, and a setting change first shows one tick after the cycle start that loads it. The bench counts ticks from the marker it drives and compares the output sampled at tick g against the formula evaluated for phase g−2. The first two ticks of each run are skipped, because they still carry the phase from before the marker. For setting changes, the bench switches from the old to the new expected setting at the first cycle boundary after the change, and not at the tick where the change was applied.

// File: rtl/skw_pkg.sv
package skw_pkg;
  localparam int unsigned SKW_W = 5;

  typedef enum logic [1:0] {TRI_L = 2'b00, TRI_M = 2'b01, TRI_H = 2'b10, TRI_Z = 2'b11} tri_e;
  typedef enum logic [1:0] {WAVE_SKEW = 2'd0, WAVE_DIV2 = 2'd1, WAVE_DIV4 = 2'd2} wave_e;

  typedef struct packed {
    logic [1:0] range_sel;
    logic [3:0] code;
    logic       div_bank;
  } cfg_t;

  // undriven level reads as mid
  function automatic logic [1:0] tri_idx(input logic [1:0] v);
    case (v)
      2'b00:   return 2'd0;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/skw_phase_cnt.sv
module skw_phase_cnt #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned CYC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mark_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic [CNT_W-1:0] ph_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] ph_q;
  logic [CYC_W-1:0] cyc_q;
  logic             synced_q;

  assign wrap_o = mark_i || (ph_q >= ratio_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      cyc_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      ph_q <= wrap_o ? '0 : ph_q + 1'b1;
      if (mark_i && !synced_q) begin
        cyc_q    <= '0;
        synced_q <= 1'b1;
      end else if (wrap_o) begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign ph_o  = ph_q;
  assign cyc_o = cyc_q;

  p_ph_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < ratio_i);

  p_mark_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i |=> (ph_q == '0));
endmodule

// File: rtl/skw_code_dec.sv
module skw_code_dec
  import skw_pkg::*;
(
  input  logic [3:0]              code_i,
  input  logic                    div_bank_i,
  output wave_e                   mode_o,
  output logic signed [SKW_W-1:0] skew_o
);
  int idx;
  int units;

  always_comb begin
    idx    = 3 * int'(tri_idx(code_i[3:2])) + int'(tri_idx(code_i[1:0]));
    units  = idx - 4;
    mode_o = WAVE_SKEW;
    skew_o = SKW_W'(units);
    if (div_bank_i) begin
      skew_o = SKW_W'(2 * units);
      if (idx == 0) begin
        mode_o = WAVE_DIV2;
        skew_o = '0;
      end else if (idx == 8) begin
        mode_o = WAVE_DIV4;
        skew_o = '0;
      end
    end
  end
endmodule

// File: rtl/skw_wave_gen.sv
module skw_wave_gen
  import skw_pkg::*;
#(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned CYC_W   = 2,
  parameter int unsigned NUM_OUT = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        ph_i,
  input  logic [CNT_W-1:0]        ratio_i,
  input  logic [CYC_W-1:0]        cyc_i,
  input  wave_e                   mode_i,
  input  logic signed [SKW_W-1:0] skew_i,
  output logic [NUM_OUT-1:0]      q_o
);
  int   rot;
  int   half;
  logic q_next;

  // phase rotated by skew, folded into [0, ratio)
  always_comb begin
    half = int'(ratio_i >> 1);
    rot  = int'(ph_i) + int'(ratio_i) - int'(skew_i);
    if (rot >= int'(ratio_i)) rot = rot - int'(ratio_i);
    if (rot >= int'(ratio_i)) rot = rot - int'(ratio_i);
    case (mode_i)
      WAVE_DIV2: q_next = ~cyc_i[0];
      WAVE_DIV4: q_next = ~cyc_i[1];
      default:   q_next = (rot < half);
    endcase
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= q_next;
    end
  end

  p_div_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) != WAVE_SKEW && $past(mode_i, 2) == $past(mode_i) && !$stable(q_o[0]))
      |-> ($past(ph_i) == '0));

  p_zero_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == WAVE_SKEW && $past(mode_i, 2) == WAVE_SKEW &&
     $past(skew_i) == '0 && $past(skew_i, 2) == '0 && $rose(q_o[0]))
      |-> ($past(ph_i) == '0));
endmodule

// File: rtl/skew_tap_shifter.sv
module skew_tap_shifter
  import skw_pkg::*;
#(
  parameter int unsigned RATIO_L = 44,
  parameter int unsigned RATIO_M = 26,
  parameter int unsigned RATIO_H = 16,
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_mark_i,
  input  logic [1:0]         range_i,
  input  logic [3:0]         code_i,
  input  logic               div_bank_i,
  output logic [NUM_OUT-1:0] q_o
);
  localparam int unsigned RATIO_MAX = (RATIO_L > RATIO_M) ?
    ((RATIO_L > RATIO_H) ? RATIO_L : RATIO_H) :
    ((RATIO_M > RATIO_H) ? RATIO_M : RATIO_H);
  localparam int unsigned CNT_W = $clog2(RATIO_MAX);
  localparam int unsigned CYC_W = 2;
  localparam cfg_t CFG_RST = '{range_sel: TRI_M, code: {TRI_M, TRI_M}, div_bank: 1'b0};

  cfg_t                    cfg_q;
  logic [CNT_W-1:0]        ratio;
  logic [CNT_W-1:0]        ph;
  logic [CYC_W-1:0]        cyc;
  logic                    wrap;
  wave_e                   mode;
  logic signed [SKW_W-1:0] skew;

  always_comb begin
    case (tri_idx(cfg_q.range_sel))
      2'd0:    ratio = CNT_W'(RATIO_L);
      2'd2:    ratio = CNT_W'(RATIO_H);
      default: ratio = CNT_W'(RATIO_M);
    endcase
  end

  // settings are captured only at a cycle start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (wrap) cfg_q <= '{range_sel: range_i, code: code_i, div_bank: div_bank_i};
  end

  skw_phase_cnt #(.CNT_W(CNT_W), .CYC_W(CYC_W)) i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mark_i  (ref_mark_i),
    .ratio_i (ratio),
    .ph_o    (ph),
    .cyc_o   (cyc),
    .wrap_o  (wrap)
  );

  skw_code_dec i_dec (
    .code_i     (cfg_q.code),
    .div_bank_i (cfg_q.div_bank),
    .mode_o     (mode),
    .skew_o     (skew)
  );

  skw_wave_gen #(.CNT_W(CNT_W), .CYC_W(CYC_W), .NUM_OUT(NUM_OUT)) i_wave (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_i    (ph),
    .ratio_i (ratio),
    .cyc_i   (cyc),
    .mode_i  (mode),
    .skew_i  (skew),
    .q_o     (q_o)
  );

  p_cfg_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> ($past(wrap) && ph == '0));
endmodule

// File: tb/test_skew_tap_shifter.sv
module test_skew_tap_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mark = 1'b0;
  logic [1:0] range_sel = 2'b01;
  logic [3:0] code = 4'b0101;
  logic       div_bank = 1'b0;
  logic [1:0] q;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  skew_tap_shifter i_skew_tap_shifter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ref_mark_i (mark),
    .range_i    (range_sel),
    .code_i     (code),
    .div_bank_i (div_bank),
    .q_o        (q)
  );

  function automatic logic [1:0] enc(input int d);
    return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [3:0] code_of(input int idx);
    return {enc(idx / 3), enc(idx % 3)};
  endfunction

  // mode: 0 skew, 1 div2, 2 div4
  function automatic logic expect_q(input int j, input int n, input int mode, input int s);
    int p = j % n;
    int c = j / n;
    if (mode == 1) return (c % 2) == 0;
    if (mode == 2) return (c % 4) < 2;
    return ((((p - s) % n) + n) % n) < n / 2;
  endfunction

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mark  = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (q !== 2'b00) begin
      n_errors++;
      $display("FAIL R10 reset outputs: actual=%b expected=00", q);
    end
    rst_n = 1'b1;
  endtask

  // Runs `cycles` reference cycles; code switches to code_b at tick gc.
  task automatic run_seq(input int n, input logic [1:0] rng, input logic div_b,
                         input logic [3:0] code_a, input int mode_a, input int s_a,
                         input logic [3:0] code_b, input int mode_b, input int s_b,
                         input int gc, input int cycles, input string req);
    int   bnd = (gc / n + 1) * n;
    int   bad_tick = -1;
    logic bad_act = 1'b0;
    logic bad_exp = 1'b0;
    int   pair_bad = 0;
    apply_reset();
    range_sel = rng;
    div_bank  = div_b;
    for (int g = 0; g < cycles * n; g++) begin
      @(negedge clk);
      if (g >= 2) begin
        int   j = g - 2;
        logic e = (j >= bnd) ? expect_q(j, n, mode_b, s_b) : expect_q(j, n, mode_a, s_a);
        if (q[0] !== e && bad_tick < 0) begin
          bad_tick = g;
          bad_act  = q[0];
          bad_exp  = e;
        end
        if (q[0] !== q[1]) pair_bad++;
      end
      code = (g >= gc) ? code_b : code_a;
      mark = ((g % n) == 0);
    end
    @(negedge clk);
    mark = 1'b0;
    n_checks++;
    if (bad_tick >= 0) begin
      n_errors++;
      $display("FAIL %s tick %0d: actual=%b expected=%b", req, bad_tick, bad_act, bad_exp);
    end
    n_checks++;
    if (pair_bad != 0) begin
      n_errors++;
      $display("FAIL R8 %s outputs differ on %0d ticks: actual=%0d expected=0", req, pair_bad, pair_bad);
    end
  endtask

  task automatic t_ranges();
    run_seq(16, 2'b10, 1'b0, 4'b0101, 0, 0, 4'b0101, 0, 0, 9999, 4, "R1 R4 R5 R10 range H");
    run_seq(26, 2'b01, 1'b0, 4'b0101, 0, 0, 4'b0101, 0, 0, 9999, 4, "R1 R4 R5 range M");
    run_seq(44, 2'b00, 1'b0, 4'b0101, 0, 0, 4'b0101, 0, 0, 9999, 3, "R1 R4 R5 range L");
  endtask

  task automatic t_undriven();
    run_seq(26, 2'b11, 1'b0, 4'b1111, 0, 0, 4'b1111, 0, 0, 9999, 3, "R2 undriven range+code");
    run_seq(16, 2'b10, 1'b0, 4'b1100, 0, -1, 4'b1100, 0, -1, 9999, 3, "R2 undriven hi digit");
  endtask

  task automatic t_normal_map();
    for (int k = 0; k < 9; k++)
      run_seq(16, 2'b10, 1'b0, code_of(k), 0, k - 4, code_of(k), 0, k - 4, 9999, 3,
              $sformatf("R3 normal code idx %0d", k));
  endtask

  task automatic t_div_skew();
    for (int k = 1; k < 8; k++)
      run_seq(26, 2'b01, 1'b1, code_of(k), 0, 2 * (k - 4), code_of(k), 0, 2 * (k - 4), 9999, 3,
              $sformatf("R6 divider bank code idx %0d", k));
  endtask

  task automatic t_dividers();
    run_seq(16, 2'b10, 1'b1, 4'b0000, 1, 0, 4'b0000, 1, 0, 9999, 6, "R7 divide by 2");
    run_seq(16, 2'b10, 1'b1, 4'b1010, 2, 0, 4'b1010, 2, 0, 9999, 9, "R7 divide by 4");
  endtask

  task automatic t_boundary();
    run_seq(16, 2'b10, 1'b0, 4'b0101, 0, 0, 4'b1010, 0, 4, 37, 5, "R9 lag change at boundary");
    run_seq(16, 2'b10, 1'b0, 4'b1001, 0, 3, 4'b0001, 0, -3, 57, 6, "R9 lead change at boundary");
  endtask

  initial begin
    #(5ns * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_ranges();
    t_undriven();
    t_normal_map();
    t_div_skew();
    t_dividers();
    t_boundary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule